// File: doc/BRIEF.md
# Timed Power-Up Interlock Sequencer

This block is the digital controller that brings a rotating-disk memory machine up and takes it down again in a safe order. It replaces a chain of timed relays. A power-on request starts the disk motor, the cooling blowers and the secondary supplies together. The disk head solenoid is held back until a spin-up interval has passed. Once the disk is engaged, all clocked logic is held in a forced-initialise state for a zeroing interval. Only after that interval are memory writes enabled and the ready indicator lit, and these two events happen in the same cycle.

Thermostats sit in the solenoid path. A latched undervoltage kickout and an input-breaker trip can shut the machine down. On a power-off request the disk is retracted first, and the motor, blowers and supplies stay alive for a short hold so that no transient reaches the disk. Every interval is a parameter counted in clock ticks, and the number of thermostats is also a parameter.

Top module: `pwrup_interlock_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is low.
- R2: When idle, a power-on request raises motor, blower, supplies and initialise in the next cycle. The solenoid stays low at that point.
- R3: The solenoid rises only after exactly SPIN_TICKS consecutive cycles in the spin-up wait with all thermostats closed.
- R4: The solenoid is high for exactly ZERO_TICKS cycles with initialise held. Then, in a single cycle, initialise falls and write-enable and ready rise. Write-enable is never high unless the solenoid is high and initialise is low.
- R5: If any thermostat input reads 0 (open), the solenoid, write-enable and ready are low in the next cycle. The sequence returns to the spin-up wait, and that wait restarts from zero on every cycle in which a thermostat is open.
- R6: A power-off request while the machine is powered drops the solenoid, write-enable and ready in the next cycle. Motor, blower, supplies and initialise stay high for exactly HOLD_TICKS cycles, and then every output is low.
- R7: A power-on request during the power-down hold is ignored. The hold still ends with every output low.
- R8: Undervoltage seen while the supplies are on turns every output off in the next cycle and latches a fault. While the fault is latched, power-on requests are ignored. A power-off request clears the fault.
- R9: A breaker trip turns every output off in the next cycle, from any state, with no hold.
- R10: Power-off has priority over power-on when both arrive in the same cycle. From idle the machine stays off. When powered, the machine enters the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Power-on request |
| pwr_off_req | input | 1 | Power-off request |
| thermo_closed | input | THERMO_N | One bit per thermostat, 1 = closed (cool) |
| undervolt | input | 1 | Undervoltage detected on a supply |
| breaker_trip | input | 1 | Input breaker overload |
| motor_on | output | 1 | Disk motor drive |
| blower_on | output | 1 | Cooling blowers |
| supplies_on | output | 1 | Secondary supplies enabled |
| solenoid_on | output | 1 | Disk engaged against the heads |
| init_hold | output | 1 | Forced-initialise of clocked logic |
| wr_enable | output | 1 | Main memory write enable |
| ready | output | 1 | Ready indicator |

## Verification
The bench counts cycles from a thermostat reclosing to the solenoid rising. A design that kept a partial spin-up count across a thermal open would engage the disk too early. The bench sends power-on during the hold and when a fault is latched. A design that honoured either request would restart the motor when it must stay dark. It also checks that ready, write-enable and the fall of initialise share one cycle, so a one-cycle skew would let writes run while logic is still being zeroed. Same-cycle on and off requests, and trips in every state, show whether the priority or the skip-the-hold path was inverted.

// File: rtl/pis_pkg.sv
package pis_pkg;

   typedef enum logic [2:0] {
      PS_OFF  = 3'd0,
      PS_SPIN = 3'd1,
      PS_ZERO = 3'd2,
      PS_RUN  = 3'd3,
      PS_HOLD = 3'd4
   } pstate_t;

   typedef struct packed {
      logic motor;
      logic blower;
      logic supplies;
      logic solenoid;
      logic init;
      logic wr;
      logic ready;
   } drive_t;

   function automatic drive_t drive_of(pstate_t s);
      drive_t d;
      d = '0;
      case (s)
         PS_SPIN, PS_HOLD: begin
            d.motor = 1'b1; d.blower = 1'b1; d.supplies = 1'b1; d.init = 1'b1;
         end
         PS_ZERO: begin
            d.motor = 1'b1; d.blower = 1'b1; d.supplies = 1'b1; d.init = 1'b1;
            d.solenoid = 1'b1;
         end
         PS_RUN: begin
            d.motor = 1'b1; d.blower = 1'b1; d.supplies = 1'b1;
            d.solenoid = 1'b1; d.wr = 1'b1; d.ready = 1'b1;
         end
         default: d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pis_timer.sv
module pis_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [CNT_W-1:0] lim,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + CNT_W'(1);
   end

   assign done = en && (cnt == lim - CNT_W'(1));

   // count never passes its limit while a timed state is active (R3, R4, R6)
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt < lim));

endmodule

// File: rtl/pis_fault_latch.sv
module pis_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic latched
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    latched <= 1'b0;
      else if (set)  latched <= 1'b1;
      else if (clr)  latched <= 1'b0;
   end

   assert_fault_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> latched);

endmodule

// File: rtl/pis_thermal_gate.sv
module pis_thermal_gate #(
   parameter int THERMO_N = 2
) (
   input  logic [THERMO_N-1:0] closed,
   output logic                all_ok
);

   generate
      if (THERMO_N == 1) begin : g_single
         assign all_ok = closed[0];
      end else begin : g_multi
         assign all_ok = &closed;
      end
   endgenerate

endmodule

// File: rtl/pwrup_interlock_seq.sv
module pwrup_interlock_seq
   import pis_pkg::*;
#(
   parameter int SPIN_TICKS = 30000,
   parameter int ZERO_TICKS = 10000,
   parameter int HOLD_TICKS = 500,
   parameter int THERMO_N   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pwr_on_req,
   input  logic                pwr_off_req,
   input  logic [THERMO_N-1:0] thermo_closed,
   input  logic                undervolt,
   input  logic                breaker_trip,
   output logic                motor_on,
   output logic                blower_on,
   output logic                supplies_on,
   output logic                solenoid_on,
   output logic                init_hold,
   output logic                wr_enable,
   output logic                ready
);

   localparam int MAX_A = (SPIN_TICKS > ZERO_TICKS) ? SPIN_TICKS : ZERO_TICKS;
   localparam int MAX_T = (MAX_A > HOLD_TICKS) ? MAX_A : HOLD_TICKS;
   localparam int CNT_W = $clog2(MAX_T + 1);

   generate
      if (SPIN_TICKS < 1 || ZERO_TICKS < 1 || HOLD_TICKS < 1) begin : g_bad_ticks
         $error("interval parameters must be at least 1");
      end
      if (THERMO_N < 1) begin : g_bad_thermo
         $error("THERMO_N must be at least 1");
      end
   endgenerate

   pstate_t          st, nxt;
   logic             therm_ok;
   logic             fault_lat;
   logic             uv_hit;
   logic             tmr_done, tmr_clr, tmr_en;
   logic [CNT_W-1:0] tmr_lim;
   drive_t           drv;

   pis_thermal_gate #(.THERMO_N(THERMO_N)) u_therm (
      .closed (thermo_closed),
      .all_ok (therm_ok)
   );

   assign uv_hit = undervolt && (st != PS_OFF);

   pis_fault_latch u_fault (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (uv_hit),
      .clr     (pwr_off_req),
      .latched (fault_lat)
   );

   always_comb begin
      case (st)
         PS_SPIN: tmr_lim = CNT_W'(SPIN_TICKS);
         PS_ZERO: tmr_lim = CNT_W'(ZERO_TICKS);
         PS_HOLD: tmr_lim = CNT_W'(HOLD_TICKS);
         default: tmr_lim = CNT_W'(1);
      endcase
   end

   assign tmr_en = (st == PS_SPIN) || (st == PS_ZERO) || (st == PS_HOLD);

   always_comb begin
      nxt = st;
      if (breaker_trip || uv_hit) begin
         nxt = PS_OFF;
      end else begin
         case (st)
            PS_OFF:  if (pwr_on_req && !pwr_off_req && !fault_lat) nxt = PS_SPIN;
            PS_SPIN: if (pwr_off_req)                  nxt = PS_HOLD;
                     else if (therm_ok && tmr_done)    nxt = PS_ZERO;
            PS_ZERO: if (pwr_off_req)                  nxt = PS_HOLD;
                     else if (!therm_ok)               nxt = PS_SPIN;
                     else if (tmr_done)                nxt = PS_RUN;
            PS_RUN:  if (pwr_off_req)                  nxt = PS_HOLD;
                     else if (!therm_ok)               nxt = PS_SPIN;
            PS_HOLD: if (tmr_done)                     nxt = PS_OFF;
            default:                                   nxt = PS_OFF;
         endcase
      end
   end

   assign tmr_clr = (nxt != st) || ((st == PS_SPIN) && !therm_ok);

   pis_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .en    (tmr_en),
      .lim   (tmr_lim),
      .done  (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= PS_OFF;
      else        st <= nxt;
   end

   assign drv         = drive_of(st);
   assign motor_on    = drv.motor;
   assign blower_on   = drv.blower;
   assign supplies_on = drv.supplies;
   assign solenoid_on = drv.solenoid;
   assign init_hold   = drv.init;
   assign wr_enable   = drv.wr;
   assign ready       = drv.ready;

   assert_pwr_on_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_OFF && pwr_on_req && !pwr_off_req && !fault_lat && !breaker_trip)
      |=> (motor_on && supplies_on && !solenoid_on));

   assert_wr_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enable |-> (solenoid_on && !init_hold && ready));

   assert_ready_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(st) == PS_ZERO));

   assert_thermo_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !therm_ok |=> (!solenoid_on && !wr_enable && !ready));

   assert_off_retracts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_off_req && !breaker_trip && !uv_hit &&
       (st == PS_SPIN || st == PS_ZERO || st == PS_RUN))
      |=> (!solenoid_on && supplies_on));

   assert_hold_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_HOLD) |=> (st == PS_HOLD || st == PS_OFF));

   assert_fault_keeps_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_lat |-> (st == PS_OFF));

   assert_trip_all_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      breaker_trip |=> (!supplies_on && !motor_on && !solenoid_on));

endmodule

// File: tb/pwrup_interlock_seq_bench.sv
`timescale 1ns/1ps
module pwrup_interlock_seq_bench;

   localparam int SPIN = 12;
   localparam int ZERO = 6;
   localparam int HOLD = 4;
   localparam int NTH  = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic           rst_n;
   logic           pwr_on_req, pwr_off_req, undervolt, breaker_trip;
   logic [NTH-1:0] thermo_closed;
   logic motor_on, blower_on, supplies_on, solenoid_on, init_hold, wr_enable, ready;

   pwrup_interlock_seq #(
      .SPIN_TICKS(SPIN), .ZERO_TICKS(ZERO), .HOLD_TICKS(HOLD), .THERMO_N(NTH)
   ) u_pwrup_interlock_seq (
      .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
      .thermo_closed(thermo_closed), .undervolt(undervolt), .breaker_trip(breaker_trip),
      .motor_on(motor_on), .blower_on(blower_on), .supplies_on(supplies_on),
      .solenoid_on(solenoid_on), .init_hold(init_hold), .wr_enable(wr_enable),
      .ready(ready)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model: 0 off, 1 spin, 2 zero, 3 run, 4 hold
   int m_st  = 0;
   int m_cnt = 0;
   bit m_lat = 1'b0;

   function automatic logic [6:0] exp_outs(int s);
      case (s)
         1, 4:    return 7'b1110100;
         2:       return 7'b1111100;
         3:       return 7'b1111011;
         default: return 7'b0000000;
      endcase
   endfunction

   function automatic logic [6:0] got_outs();
      return {motor_on, blower_on, supplies_on, solenoid_on, init_hold, wr_enable, ready};
   endfunction

   task automatic model_step(input bit on, input bit off, input bit tok, input bit uv,
                             input bit trip);
      int nst;
      bit uvh;
      uvh = uv && (m_st != 0);
      nst = m_st;
      if (trip || uvh) nst = 0;
      else begin
         case (m_st)
            0: if (on && !off && !m_lat) nst = 1;
            1: if (off) nst = 4; else if (tok && m_cnt == SPIN-1) nst = 2;
            2: if (off) nst = 4; else if (!tok) nst = 1; else if (m_cnt == ZERO-1) nst = 3;
            3: if (off) nst = 4; else if (!tok) nst = 1;
            4: if (m_cnt == HOLD-1) nst = 0;
            default: nst = 0;
         endcase
      end
      if (uvh) m_lat = 1'b1;
      else if (off) m_lat = 1'b0;
      if (nst != m_st || (m_st == 1 && !tok)) m_cnt = 0;
      else if (m_st == 1 || m_st == 2 || m_st == 4) m_cnt = m_cnt + 1;
      m_st = nst;
   endtask

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // called just after a negedge: drive, clock, update model, compare
   task automatic step(input bit on, input bit off, input logic [NTH-1:0] th,
                       input bit uv, input bit trip, input string tag);
      pwr_on_req = on; pwr_off_req = off; thermo_closed = th;
      undervolt = uv; breaker_trip = trip;
      @(posedge clk);
      model_step(on, off, &th, uv, trip);
      @(negedge clk);
      chk(got_outs() == exp_outs(m_st), tag, int'(got_outs()), int'(exp_outs(m_st)));
   endtask

   task automatic idle(input string tag);
      step(1'b0, 1'b0, '1, 1'b0, 1'b0, tag);
   endtask

   task automatic settle();
      step(1'b0, 1'b1, '1, 1'b0, 1'b0, "settle R6");
      repeat (HOLD + 1) idle("settle R6");
   endtask

   task automatic run_up(input string tag);
      step(1'b1, 1'b0, '1, 1'b0, 1'b0, tag);
      repeat (SPIN + ZERO) idle(tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; pwr_on_req = 1'b1; pwr_off_req = 1'b0; thermo_closed = '1;
      undervolt = 1'b0; breaker_trip = 1'b0;
      repeat (3) @(negedge clk);
      chk(got_outs() == 7'b0, "R1 in reset", int'(got_outs()), 0);
      pwr_on_req = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(got_outs() == 7'b0, "R1 after release", int'(got_outs()), 0);

      // R2: power on
      step(1'b1, 1'b0, '1, 1'b0, 1'b0, "R2 power on");
      chk(motor_on && blower_on && supplies_on && init_hold && !solenoid_on,
          "R2 start set", int'(got_outs()), int'(7'b1110100));
      // R3: spin-up length
      n = 0;
      while (!solenoid_on && n < 200) begin idle("R3 spin"); n++; end
      chk(n == SPIN, "R3 spin ticks", n, SPIN);
      // R4: zeroing length and same-cycle release
      n = 0;
      while (!ready && n < 200) begin idle("R4 zero"); n++; end
      chk(n == ZERO, "R4 zero ticks", n, ZERO);
      chk(!init_hold && wr_enable && ready && solenoid_on, "R4 release together",
          int'(got_outs()), int'(7'b1111011));

      // R5: thermostat open while running
      step(1'b0, 1'b0, 2'b10, 1'b0, 1'b0, "R5 open");
      chk(!solenoid_on && !wr_enable && !ready && motor_on, "R5 drop",
          int'(got_outs()), int'(7'b1110100));
      repeat (SPIN + 3) step(1'b0, 1'b0, 2'b01, 1'b0, 1'b0, "R5 still open");
      chk(!solenoid_on, "R5 held while open", solenoid_on, 0);
      n = 0;
      while (!solenoid_on && n < 200) begin idle("R5 reclose"); n++; end
      chk(n == SPIN, "R5 full restart", n, SPIN);
      repeat (ZERO) idle("R5 back to run");

      // R6: power off from run
      step(1'b0, 1'b1, '1, 1'b0, 1'b0, "R6 off");
      chk(!solenoid_on && supplies_on && motor_on && !ready, "R6 retract first",
          int'(got_outs()), int'(7'b1110100));
      n = 0;
      while (supplies_on && n < 200) begin idle("R6 hold"); n++; end
      chk(n == HOLD, "R6 hold ticks", n, HOLD);

      // R7: power-on during hold ignored
      run_up("R7 up");
      step(1'b0, 1'b1, '1, 1'b0, 1'b0, "R7 off");
      step(1'b1, 1'b0, '1, 1'b0, 1'b0, "R7 on in hold");
      repeat (HOLD + 3) idle("R7 after hold");
      chk(!motor_on && !supplies_on, "R7 stays off", motor_on, 0);

      // R8: undervoltage latch
      run_up("R8 up");
      step(1'b0, 1'b0, '1, 1'b1, 1'b0, "R8 uv");
      chk(got_outs() == 7'b0, "R8 all off", int'(got_outs()), 0);
      step(1'b1, 1'b0, '1, 1'b0, 1'b0, "R8 on ignored");
      chk(!motor_on, "R8 latched", motor_on, 0);
      step(1'b0, 1'b1, '1, 1'b0, 1'b0, "R8 clear");
      step(1'b1, 1'b0, '1, 1'b0, 1'b0, "R8 on again");
      chk(motor_on, "R8 restart after clear", motor_on, 1);
      settle();

      // R9: trip in zeroing, and in hold
      step(1'b1, 1'b0, '1, 1'b0, 1'b0, "R9 on");
      repeat (SPIN + 2) idle("R9 to zero");
      step(1'b0, 1'b0, '1, 1'b0, 1'b1, "R9 trip zero");
      chk(got_outs() == 7'b0, "R9 trip zero off", int'(got_outs()), 0);
      run_up("R9 up");
      step(1'b0, 1'b1, '1, 1'b0, 1'b0, "R9 off");
      step(1'b0, 1'b0, '1, 1'b0, 1'b1, "R9 trip hold");
      chk(!supplies_on, "R9 no hold after trip", supplies_on, 0);

      // R10: off wins over on
      step(1'b1, 1'b1, '1, 1'b0, 1'b0, "R10 both idle");
      chk(!motor_on, "R10 stays off", motor_on, 0);
      run_up("R10 up");
      step(1'b1, 1'b1, '1, 1'b0, 1'b0, "R10 both run");
      chk(supplies_on && !solenoid_on, "R10 enters hold", int'(got_outs()),
          int'(7'b1110100));
      repeat (HOLD + 1) idle("R10 settle");

      // random mix covering R2 R3 R4 R5 R6 R7 R8 R9 R10
      for (int i = 0; i < 4000; i++) begin
         logic [NTH-1:0] th;
         bit on, off, uv, trip;
         on   = ($urandom % 100) < 8;
         off  = ($urandom % 100) < 2;
         uv   = ($urandom % 1000) < 4;
         trip = ($urandom % 1000) < 3;
         for (int b = 0; b < NTH; b++) th[b] = (($urandom % 1000) >= 8);
         step(on, off, th, uv, trip, "random R5 R6 R8 mix");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule